// File: doc/BRIEF.md
# Serial ADC Link Master

This block is the host end of a three-wire link to an 8-bit successive-approximation converter with an input multiplexer. On a start request it pulls chip select low, produces a serial clock from the system clock through a divider, and sends a frame made of a start bit and a channel address. It then lets go of the shared data pin, gives the converter one clock period to settle its multiplexer, and collects the result bits, most significant first.

The converter reads its data input only while the address is being sent. It drives its output only after that. One bidirectional pin can therefore carry both directions. The block exposes that pin as an output value, an output enable and an input value, so the pad can be built around it. When the check option is set for a transfer, the block clocks seven further bits. These are the converter's repeat of the same result, least significant first. The block rebuilds the repeated value and flags a mismatch with the first stream.

At the end of a frame the result byte, a one-cycle completion pulse and the error flag are presented together.

Top module: `adc_link_master`

## Requirements
- R1: After reset and whenever the link is idle, chip select is high, the serial clock is low, the data pin is released (enable 0), the completion pulse is low, and the result and error outputs are 0.
- R2: The frame driven on the data pin is `1` (start), then the mode bit (1 = single-ended, 0 = differential), then the odd/sign bit, then the select bits most significant first. Each bit is stable while the serial clock is high, and the enable is 1 at every rising edge of the address.
- R3: Every high phase of the serial clock lasts DIV_HALF system cycles. Every low phase while chip select is low also lasts DIV_HALF cycles, including the lead-in from the fall of chip select to the first rising edge.
- R4: The data pin enable falls together with the falling serial clock edge that ends the last address bit. It stays 0 for the rest of the frame, so the block never drives while the converter does.
- R5: The bit present during the one settling clock period after the address is discarded and does not reach the result.
- R6: The next 8 bits, sampled just before each rising serial clock edge, form the result with the first bit as bit 7.
- R7: Chip select stays low for the whole frame and rises with the final falling clock edge. It then stays high for at least DIV_HALF cycles before another frame may start.
- R8: The completion pulse is high for exactly one system cycle, in the cycle chip select has just risen. The result and error outputs are valid with it and hold their value until the next completion.
- R9: With the check input set at the request, the frame runs 7 extra clock periods and the rebuilt replay is compared with the result. The error flag is 1 exactly when they differ. With the check input clear, the frame ends after the 8th result bit and the error flag is 0.
- R10: A request is accepted only when the link is idle. A request raised during a frame or its trailing chip-select-high gap starts no new frame and alters neither the address sent nor the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Start request, sampled while idle |
| sgl_i | input | 1 | Mode bit: 1 single-ended, 0 differential |
| odd_i | input | 1 | Odd/sign bit of the address |
| sel_i | input | SEL_W | Channel select bits |
| chk_i | input | 1 | Capture and compare the least-significant-first replay |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| sd_o | output | 1 | Data pin value driven by the block |
| sd_oe_o | output | 1 | Data pin drive enable |
| sd_i | input | 1 | Data pin value as seen at the pad |
| data_o | output | RES_W | Conversion result |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Replay mismatch flag |

## Verification
The bench builds the block with DIV_HALF = 4, SEL_W = 2 and RES_W = 8. With these values a checked frame is 21 serial periods of 8 system cycles each. That keeps each scenario short enough to cover both modes, all-zero and all-ones results, an injected replay error, a settle bit driven high and requests raised in the middle of a frame. The bench holds a behavioural converter that shares the single data wire. This lets it see the address bits exactly as a converter would latch them, and catch any cycle in which both ends drive.

// File: rtl/adc_link_pkg.sv
// Package: shared types for the serial ADC link master.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package adc_link_pkg;

    // Top-level sequencing states of the link.
    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,   // chip select high, waiting for a request
        LS_RUN  = 2'd1,   // frame in progress, serial clock toggling
        LS_GAP  = 2'd2    // chip select high for one half period after a frame
    } link_state_t;

endpackage

// File: rtl/adc_link_clkdiv.sv
// Module: half-period tick generator for the serial clock.
// Emits one tick every HALF system cycles while run_i is high; the count
// restarts from zero whenever run_i is low, so the first tick arrives HALF
// cycles after run_i rises. Assumes HALF >= 1.
module adc_link_clkdiv #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    // Tick on the last count of each half period.
    assign tick_o = run_i && (cnt_q == LAST);

    // Count system cycles within a half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_link_txframe.sv
// Module: address frame shifter.
// Loads the start bit plus address in one cycle and presents its most
// significant bit; each shift moves the next bit out. Assumes the caller
// shifts only on falling serial clock edges so bits are stable while high.
module adc_link_txframe #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] word_i,
    input  logic          shift_i,
    output logic          bit_o
);
    logic [AW-1:0] sh_q;

    assign bit_o = sh_q[AW-1];

    // Hold, load or advance the outgoing frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= word_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[AW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/adc_link_rxcap.sv
// Module: result capture with replay comparison.
// fwd_i strobes the most-significant-first stream into fwd_o; rev_i strobes
// the replay bits (bit 1 up to the top bit) into a second register. The
// replay value is rebuilt with the forward stream's last bit as its bit 0.
// Assumes all RES_W forward bits arrive before any replay bit.
module adc_link_rxcap #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             fwd_i,
    input  logic             rev_i,
    input  logic             bit_i,
    output logic [RES_W-1:0] fwd_o,
    output logic             mismatch_o
);
    logic [RES_W-1:0] fwd_q;
    logic [RES_W-2:0] rev_q;

    assign fwd_o      = fwd_q;
    assign mismatch_o = ({rev_q, fwd_q[0]} != fwd_q);

    // Shift forward bits in at the bottom, replay bits in at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            fwd_q <= '0;
            rev_q <= '0;
        end else begin
            if (fwd_i) begin
                fwd_q <= {fwd_q[RES_W-2:0], bit_i};
            end
            if (rev_i) begin
                if (RES_W > 2) begin
                    rev_q <= {bit_i, rev_q[RES_W-2:1]};
                end else begin
                    rev_q <= bit_i;
                end
            end
        end
    end
endmodule

// File: rtl/adc_link_master.sv
// Module: host-side controller for a serial 8-bit ADC link.
// Runs one frame per accepted request: chip select low, start bit and
// address on the shared data pin, pin release, one settling period, RES_W
// result bits most significant first, and optionally RES_W-1 replay bits.
// Assumes DIV_HALF is picked so the serial clock falls within the
// converter's frequency window; the high and low phases are equal.
module adc_link_master
    import adc_link_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int SEL_W    = 2,
    parameter int RES_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             sgl_i,
    input  logic             odd_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             chk_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             sd_o,
    output logic             sd_oe_o,
    input  logic             sd_i,
    output logic [RES_W-1:0] data_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int ADDR_W = 3 + SEL_W;              // start + mode + odd + select
    localparam int FWD_LO = ADDR_W + 1;             // first result period
    localparam int FWD_HI = ADDR_W + RES_W;         // last result period
    localparam int REV_HI = ADDR_W + 2 * RES_W - 1; // last replay period
    localparam int PER_W  = $clog2(REV_HI + 1);

    localparam logic [PER_W-1:0] P_ADDR_END = PER_W'(ADDR_W - 1);
    localparam logic [PER_W-1:0] P_FWD_LO   = PER_W'(FWD_LO);
    localparam logic [PER_W-1:0] P_FWD_HI   = PER_W'(FWD_HI);
    localparam logic [PER_W-1:0] P_REV_HI   = PER_W'(REV_HI);

    link_state_t      state_q;
    logic [PER_W-1:0] per_q;
    logic             chk_q;
    logic             tick;
    logic             rise_stb;
    logic             fall_stb;
    logic             start_stb;
    logic             fwd_stb;
    logic             rev_stb;
    logic             tx_shift;
    logic [PER_W-1:0] last_per;
    logic [RES_W-1:0] fwd_val;
    logic             mismatch;

    // Half-period ticks run only while a frame or gap is in progress.
    adc_link_clkdiv #(.HALF(DIV_HALF)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q != LS_IDLE),
        .tick_o (tick)
    );

    adc_link_txframe #(.AW(ADDR_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_stb),
        .word_i  ({1'b1, sgl_i, odd_i, sel_i}),
        .shift_i (tx_shift),
        .bit_o   (sd_o)
    );

    adc_link_rxcap #(.RES_W(RES_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (start_stb),
        .fwd_i      (fwd_stb),
        .rev_i      (rev_stb),
        .bit_i      (sd_i),
        .fwd_o      (fwd_val),
        .mismatch_o (mismatch)
    );

    // Decode edge strobes and which period each strobe belongs to.
    always_comb begin
        start_stb = (state_q == LS_IDLE) && req_i;
        rise_stb  = (state_q == LS_RUN) && tick && !sclk_o;
        fall_stb  = (state_q == LS_RUN) && tick && sclk_o;
        fwd_stb   = rise_stb && (per_q >= P_FWD_LO) && (per_q <= P_FWD_HI);
        rev_stb   = rise_stb && (per_q > P_FWD_HI);
        tx_shift  = fall_stb && (per_q <= P_ADDR_END);
        last_per  = chk_q ? P_REV_HI : P_FWD_HI;
    end

    // Frame sequencer: chip select, serial clock, pin enable and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            per_q   <= '0;
            chk_q   <= 1'b0;
            cs_n_o  <= 1'b1;
            sclk_o  <= 1'b0;
            sd_oe_o <= 1'b0;
            data_o  <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                LS_IDLE: begin
                    if (req_i) begin
                        state_q <= LS_RUN;
                        per_q   <= '0;
                        chk_q   <= chk_i;
                        cs_n_o  <= 1'b0;
                        sd_oe_o <= 1'b1;
                    end
                end
                LS_RUN: begin
                    if (tick) begin
                        if (!sclk_o) begin
                            sclk_o <= 1'b1;
                        end else begin
                            sclk_o <= 1'b0;
                            if (per_q == P_ADDR_END) begin
                                sd_oe_o <= 1'b0;
                            end
                            if (per_q == last_per) begin
                                state_q <= LS_GAP;
                                cs_n_o  <= 1'b1;
                                done_o  <= 1'b1;
                                data_o  <= fwd_val;
                                err_o   <= chk_q && mismatch;
                            end else begin
                                per_q <= per_q + 1'b1;
                            end
                        end
                    end
                end
                LS_GAP: begin
                    if (tick) begin
                        state_q <= LS_IDLE;
                    end
                end
                default: state_q <= LS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_link_master_chk.sv
// Module: protocol checker bound to adc_link_master.
// Watches only the link pins and the completion pulse; phase lengths are
// measured with small saturating counters instead of long $past windows.
module adc_link_master_chk #(
    parameter int DIV_HALF = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sclk_o,
    input logic sd_o,
    input logic sd_oe_o,
    input logic done_o
);
    localparam int RW = $clog2(DIV_HALF + 2) + 1;
    localparam logic [RW-1:0] RMAX = {RW{1'b1}};
    localparam logic [RW-1:0] HALF_V = RW'(DIV_HALF);

    logic [RW-1:0] hi_run;
    logic [RW-1:0] lo_run;
    logic [RW-1:0] cs_run;
    logic          seen_frame;

    // Length of the current high phase, of the current in-frame low phase,
    // and of the current chip-select-high stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run     <= '0;
            lo_run     <= '0;
            cs_run     <= '0;
            seen_frame <= 1'b0;
        end else begin
            hi_run <= !sclk_o ? '0 : ((hi_run == RMAX) ? hi_run : hi_run + 1'b1);
            lo_run <= (sclk_o || cs_n_o) ? '0 : ((lo_run == RMAX) ? lo_run : lo_run + 1'b1);
            cs_run <= !cs_n_o ? '0 : ((cs_run == RMAX) ? cs_run : cs_run + 1'b1);
            if (done_o) begin
                seen_frame <= 1'b1;
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> (!sclk_o && !sd_oe_o));

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe_o && sclk_o) |-> $stable(sd_o));

    p_high_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_run == HALF_V));

    p_low_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (lo_run == HALF_V));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_oe_o) |-> (!sclk_o && !cs_n_o));

    p_drive_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_oe_o) |-> $fell(cs_n_o));

    p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o) && seen_frame) |-> (cs_run >= HALF_V));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(cs_n_o));
endmodule

bind adc_link_master adc_link_master_chk #(.DIV_HALF(DIV_HALF)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .sd_o    (sd_o),
    .sd_oe_o (sd_oe_o),
    .done_o  (done_o)
);

// File: tb/adc_link_master_tb_top.sv
// Bench: directed scenarios against a behavioural converter sharing one wire.
module adc_link_master_tb_top;
    localparam int DIV_HALF = 4;
    localparam int SEL_W    = 2;
    localparam int RES_W    = 8;
    localparam int N_TX     = 3 + SEL_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_i, sgl_i, odd_i, chk_i;
    logic [SEL_W-1:0] sel_i;
    logic             cs_n_o, sclk_o, sd_o, sd_oe_o, sd_i, done_o, err_o;
    logic [RES_W-1:0] data_o;

    int n_chk = 0;
    int n_bad = 0;

    // converter model state
    int               rcnt = 0;
    int               fcnt = 0;
    logic [7:0]       addr_q = '0;
    bit               addr_oe_bad = 0;
    bit               drv = 0;
    logic             val = 1'b0;
    logic [RES_W-1:0] code = '0;
    bit               corrupt = 0;
    logic             settle_val = 1'b0;
    bit               conflict = 0;

    // monitors
    int hi = 0, lo = 0, hi_bad = 0, lo_bad = 0, hi_seen = 0;
    int cs_falls = 0;

    always #2 clk = ~clk;

    adc_link_master #(.DIV_HALF(DIV_HALF), .SEL_W(SEL_W), .RES_W(RES_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .sgl_i(sgl_i), .odd_i(odd_i),
        .sel_i(sel_i), .chk_i(chk_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .sd_o(sd_o), .sd_oe_o(sd_oe_o), .sd_i(sd_i), .data_o(data_o),
        .done_o(done_o), .err_o(err_o)
    );

    // shared wire with a weak pull-up
    assign sd_i = sd_oe_o ? sd_o : (drv ? val : 1'b1);

    always @(negedge cs_n_o) begin
        rcnt = 0; fcnt = 0; drv = 0; addr_q = '0; addr_oe_bad = 0;
        cs_falls++;
    end
    always @(posedge cs_n_o) drv = 0;

    always @(posedge sclk_o) begin
        if (!cs_n_o) begin
            rcnt++;
            if (rcnt <= N_TX) begin
                addr_q = {addr_q[6:0], sd_o};
                if (!sd_oe_o) addr_oe_bad = 1;
            end
        end
    end

    always @(negedge sclk_o) begin
        if (!cs_n_o) begin
            fcnt++;
            if (fcnt == N_TX) begin
                drv = 1; val = settle_val;
            end else if (fcnt > N_TX && fcnt <= N_TX + RES_W) begin
                val = code[N_TX + RES_W - fcnt];
            end else if (fcnt > N_TX + RES_W && fcnt <= N_TX + 2 * RES_W - 1) begin
                val = code[fcnt - N_TX - RES_W] ^ (corrupt && (fcnt == N_TX + RES_W + 3));
            end else begin
                val = 1'b0;
            end
        end
    end

    always @(negedge clk) if (drv && sd_oe_o) conflict = 1;

    // phase length monitor (pre-edge values)
    always @(posedge clk) begin
        if (rst_n) begin
            if (sclk_o) hi++;
            else begin
                if (hi != 0) begin hi_seen++; if (hi != DIV_HALF) hi_bad++; end
                hi = 0;
            end
            if (!cs_n_o && !sclk_o) lo++;
            else begin
                if (sclk_o && lo != 0 && lo != DIV_HALF) lo_bad++;
                lo = 0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic sgl, input logic odd, input logic [SEL_W-1:0] sel,
                             input logic chk, input int len);
        @(negedge clk);
        sgl_i = sgl; odd_i = odd; sel_i = sel; chk_i = chk; req_i = 1'b1;
        repeat (len) @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int w = 0;
        while (!done_o && w < 3000) begin @(negedge clk); w++; end
        check(done_o == 1'b1, {tag, " R8 completion seen"}, done_o, 1);
    endtask

    task automatic run_frame(input logic sgl, input logic odd, input logic [SEL_W-1:0] sel,
                             input logic chk, input logic [RES_W-1:0] c, input bit corr,
                             input logic sv, input string tag);
        logic [N_TX-1:0] exp_addr;
        int exp_rise;
        exp_addr = {1'b1, sgl, odd, sel};
        exp_rise = chk ? (N_TX + 2 * RES_W) : (N_TX + 1 + RES_W);
        code = c; corrupt = corr; settle_val = sv; conflict = 0;
        pulse_req(sgl, odd, sel, chk, 1);
        wait_done(tag);
        check(cs_n_o == 1'b1, {tag, " R7 cs high at completion"}, cs_n_o, 1);
        check(sd_oe_o == 1'b0, {tag, " R4 pin released at end"}, sd_oe_o, 0);
        check(data_o == c, {tag, " R6 result"}, data_o, c);
        check(err_o == (chk && corr), {tag, " R9 error flag"}, err_o, chk && corr);
        check(addr_q[N_TX-1:0] == exp_addr, {tag, " R2 address bits"}, addr_q, exp_addr);
        check(!addr_oe_bad, {tag, " R2 enable during address"}, addr_oe_bad, 0);
        check(rcnt == exp_rise, {tag, " R9 clock count"}, rcnt, exp_rise);
        check(!conflict, {tag, " R4 no drive overlap"}, conflict, 0);
        @(negedge clk);
        check(done_o == 1'b0, {tag, " R8 pulse one cycle"}, done_o, 0);
        repeat (2 * DIV_HALF) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; req_i = 0; sgl_i = 0; odd_i = 0; sel_i = '0; chk_i = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n_o == 1'b1, "R1 cs idle", cs_n_o, 1);
        check(sclk_o == 1'b0, "R1 sclk idle", sclk_o, 0);
        check(sd_oe_o == 1'b0, "R1 pin released", sd_oe_o, 0);
        check(done_o == 1'b0 && err_o == 1'b0, "R1 flags idle", {done_o, err_o}, 0);
        check(data_o == '0, "R1 result zero", data_o, 0);
    endtask

    task automatic t_single;
        run_frame(1'b1, 1'b0, 2'b10, 1'b0, 8'hA5, 0, 1'b0, "t_single");
        run_frame(1'b1, 1'b1, 2'b01, 1'b0, 8'h5A, 0, 1'b0, "t_single2");
    endtask

    task automatic t_diff_check;
        run_frame(1'b0, 1'b1, 2'b01, 1'b1, 8'h3C, 0, 1'b0, "t_diff_a");
        run_frame(1'b0, 1'b0, 2'b11, 1'b1, 8'h00, 0, 1'b0, "t_diff_zero");
        run_frame(1'b1, 1'b1, 2'b00, 1'b1, 8'hFF, 0, 1'b0, "t_diff_ones");
    endtask

    task automatic t_corrupt;
        run_frame(1'b0, 1'b1, 2'b10, 1'b1, 8'h96, 1, 1'b0, "t_corrupt R9");
        // error bit held after completion (R8)
        repeat (20) @(negedge clk);
        check(err_o == 1'b1, "t_hold R8 error held", err_o, 1);
        check(data_o == 8'h96, "t_hold R8 result held", data_o, 8'h96);
        // corrupted replay ignored when check is off
        run_frame(1'b0, 1'b0, 2'b00, 1'b0, 8'h69, 1, 1'b0, "t_corrupt_off R9");
    endtask

    task automatic t_settle;
        run_frame(1'b1, 1'b0, 2'b11, 1'b0, 8'h01, 0, 1'b1, "t_settle R5");
        run_frame(1'b1, 1'b0, 2'b00, 1'b1, 8'h7E, 0, 1'b1, "t_settle_chk R5");
    endtask

    task automatic t_busy;
        int f0;
        f0 = cs_falls;
        code = 8'hC3; corrupt = 0; settle_val = 1'b0;
        pulse_req(1'b1, 1'b0, 2'b01, 1'b0, 1);
        repeat (40) @(negedge clk);
        pulse_req(1'b0, 1'b1, 2'b10, 1'b1, 3);
        wait_done("t_busy");
        // request during the trailing gap
        sgl_i = 1'b0; odd_i = 1'b1; sel_i = 2'b11; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (60) @(negedge clk);
        check(cs_falls - f0 == 1, "t_busy R10 single frame", cs_falls - f0, 1);
        check(addr_q[N_TX-1:0] == 5'b11001, "t_busy R10 address kept", addr_q, 5'b11001);
        check(data_o == 8'hC3 && err_o == 1'b0, "t_busy R10 result kept", data_o, 8'hC3);
    endtask

    task automatic t_phase;
        check(hi_bad == 0, "R3 high phase length", hi_bad, 0);
        check(lo_bad == 0, "R3 low phase length", lo_bad, 0);
        check(hi_seen > 100, "R3 phases observed", hi_seen, 101);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog actual=150000 cycles expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_diff_check();
        t_corrupt();
        t_settle();
        t_busy();
        t_phase();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule